// File: doc/BRIEF.md
# Selectable-Event Parallel Input Latch

This block is the 16-bit input register of a parallel peripheral port. The raw input lines are split into two byte lanes. Lines 0 to 7 form the low byte and lines 8 to 15 the high byte. Each lane has its own choice of the event that loads it. The choices are the host read strobe, the peripheral flag moving from ready to busy, or the flag moving from busy back to ready. When the port runs a DMA transfer, the read choice follows the DMA acknowledge instead of the host strobe.

The data lines, the flag, the read strobe and the DMA acknowledge are all asynchronous to the core clock. Polarity is applied first. Each line then passes through a two-flop synchroniser, and only then are edges detected. A detected event sets a per-lane pending bit. On the following clock the lane loads the synchronised data.

In narrow (8-bit) operation only the low lane is ever loaded. The high lane keeps whatever it last held.

Top module: `pio_input_latch`

## Requirements
- R1: After reset, `word_out` is 16'h0000.
- R2: Input line i drives output bit i, so lines 0–7 land in bits 7:0 and lines 8–15 in bits 15:8. The captured bit equals the line level when `line_high_true[i]`=1 and its inverse when it is 0.
- R3: A lane whose select is 2'b00 loads on the rising edge of `rd_strobe` while `dma_mode`=0. A pulse on `dma_ack` alone leaves it unchanged.
- R4: While `dma_mode`=1, a select of 2'b00 loads on the rising edge of `dma_ack`, and a pulse on `rd_strobe` alone leaves the lane unchanged.
- R5: The logical flag equals `flag_in` when `flag_high_true`=1 and its inverse otherwise. Logical 1 means busy and logical 0 means ready. A select of 2'b01 loads on the logical 0→1 (ready-to-busy) edge.
- R6: A select of 2'b10 loads on the logical flag's 1→0 (busy-to-ready) edge.
- R7: The reserved select 2'b11 behaves exactly like 2'b00.
- R8: The lanes are independent. An event loads only the lanes whose own select names it, and the other lane keeps its value.
- R9: If `rd_strobe` rises and `line_in` changes before the same clock edge, `word_out` shows the new value on the fourth rising edge, counting that edge as the first. Before that it shows the old value.
- R10: While `narrow_mode`=1, bits 15:8 of `word_out` never change, and the low lane still loads normally.
- R11: Without a selected event, `word_out` holds, even when `line_in` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 16 | Raw asynchronous data input lines |
| line_high_true | input | 16 | Per-line sense: 1 = high-true, 0 = low-true |
| flag_in | input | 1 | Raw peripheral flag line |
| flag_high_true | input | 1 | Flag sense: 1 = high-true, 0 = low-true |
| rd_strobe | input | 1 | Host read strobe of the register |
| dma_mode | input | 1 | 1 = read choice follows the DMA acknowledge |
| dma_ack | input | 1 | DMA acknowledge |
| byte_src_sel | input | 4 | Load-event select; bits 1:0 for the low lane, 3:2 for the high lane |
| narrow_mode | input | 1 | 1 = 8-bit operation, high lane frozen |
| word_out | output | 16 | Latched word as seen by the host |

## Verification
A stuck or spurious pending bit in a lane shows at the ports on the next clock. That lane either misses a load or loads data with no event behind it, and the sweep sees this at its settle point a few cycles after each stimulus. A wrong edge-detector history makes a lane answer the opposite flag edge, or answer twice. A mis-wired synchroniser stage moves the load away from the fourth clock edge, which the latency test pins exactly. Every select value is crossed with every event kind in both lanes, with the flag and data polarities varied. A lane that loads on the wrong event therefore shows a wrong byte at the first check after that event.

// File: rtl/pio_in_pkg.sv
package pio_in_pkg;

    typedef enum logic [1:0] {
        SRC_READ  = 2'b00,
        SRC_BUSY  = 2'b01,
        SRC_READY = 2'b10,
        SRC_RSVD  = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic read;
        logic busy;
        logic ready;
    } cap_evt_t;

    // Does the selected source fire for this set of events?
    function automatic logic src_hit(input logic [1:0] sel, input cap_evt_t evt);
        logic hit;
        case (src_sel_e'(sel))
            SRC_BUSY:  hit = evt.busy;
            SRC_READY: hit = evt.ready;
            default:   hit = evt.read; // read and reserved
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            state_d.chain[i] = state_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_o = state_q.chain[STAGES-1];

endmodule

// File: rtl/pio_in_edge.sv
module pio_in_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic edge_o
);

    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.prev = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = level_i & ~state_q.prev;
        end else begin : g_fall
            assign edge_o = ~level_i & state_q.prev;
        end
    endgenerate

    // One transition cannot be reported on two cycles in a row (R5, R6)
    assert_single_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/pio_in_byte_cap.sv
module pio_in_byte_cap
    import pio_in_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] data_i,
    input  logic [1:0]        sel_i,
    input  cap_evt_t          evt_i,
    input  logic              load_en_i,
    output logic [BYTE_W-1:0] byte_o
);

    typedef struct packed {
        logic              pend;
        logic [BYTE_W-1:0] val;
    } lane_state_t;

    lane_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.pend = src_hit(sel_i, evt_i);
        if (state_q.pend && load_en_i) begin
            state_d.val = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign byte_o = state_q.val;

    assert_hold_without_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.pend |=> $stable(byte_o));

    assert_rsvd_as_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b11 && !evt_i.read) |=> !state_q.pend);

    assert_busy_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b01 && evt_i.busy) |=> state_q.pend);

    assert_ready_arms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b10 && evt_i.ready) |=> state_q.pend);

endmodule

// File: rtl/pio_input_latch.sv
module pio_input_latch
    import pio_in_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DATA_W-1:0]          line_in,
    input  logic [DATA_W-1:0]          line_high_true,
    input  logic                       flag_in,
    input  logic                       flag_high_true,
    input  logic                       rd_strobe,
    input  logic                       dma_mode,
    input  logic                       dma_ack,
    input  logic [2*(DATA_W/BYTE_W)-1:0] byte_src_sel,
    input  logic                       narrow_mode,
    output logic [DATA_W-1:0]          word_out
);

    localparam int NUM_BYTES = DATA_W / BYTE_W;
    localparam int CTRL_W    = 3;
    localparam int SYNC_W    = DATA_W + CTRL_W;
    localparam int NUM_EDGES = 4;
    // edge detector roles: 0 busy, 1 ready, 2 strobe, 3 ack
    localparam logic [NUM_EDGES-1:0] EDGE_RISING = 4'b1101;

    logic [SYNC_W-1:0]    raw_logical;
    logic [SYNC_W-1:0]    synced;
    logic [DATA_W-1:0]    data_s;
    logic                 flag_s, strobe_s, ack_s;
    logic [NUM_EDGES-1:0] edge_lvl;
    logic [NUM_EDGES-1:0] edge_hit;
    cap_evt_t             evt;

    // Polarity first, so a sense change together with a line change is glitch-free
    assign raw_logical = {dma_ack, rd_strobe, flag_in ^ ~flag_high_true,
                          line_in ^ ~line_high_true};

    pio_in_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_logical),
        .sync_o  (synced)
    );

    assign data_s   = synced[DATA_W-1:0];
    assign flag_s   = synced[DATA_W];
    assign strobe_s = synced[DATA_W+1];
    assign ack_s    = synced[DATA_W+2];
    assign edge_lvl = {ack_s, strobe_s, flag_s, flag_s};

    generate
        for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
            pio_in_edge #(.RISING(EDGE_RISING[e])) edge_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .level_i (edge_lvl[e]),
                .edge_o  (edge_hit[e])
            );
        end
    endgenerate

    always_comb begin
        evt.busy  = edge_hit[0];
        evt.ready = edge_hit[1];
        evt.read  = dma_mode ? edge_hit[3] : edge_hit[2];
    end

    generate
        for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
            logic lane_en;
            assign lane_en = (b == 0) || !narrow_mode;
            pio_in_byte_cap #(.BYTE_W(BYTE_W)) lane_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .data_i    (data_s[b*BYTE_W +: BYTE_W]),
                .sel_i     (byte_src_sel[2*b +: 2]),
                .evt_i     (evt),
                .load_en_i (lane_en),
                .byte_o    (word_out[b*BYTE_W +: BYTE_W])
            );
        end
    endgenerate

    generate
        if (NUM_BYTES > 1) begin : g_narrow_chk
            assert_narrow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
                narrow_mode |=> $stable(word_out[DATA_W-1:BYTE_W]));
        end
    endgenerate

    // Read choice in DMA mode ignores a lone host strobe (R4)
    assert_dma_ignores_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && !edge_hit[3]) |-> !evt.read);

endmodule

// File: tb/pio_input_latch_tb_top.sv
module pio_input_latch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] line_in;
    logic [15:0] line_high_true;
    logic        flag_in;
    logic        flag_high_true;
    logic        rd_strobe;
    logic        dma_mode;
    logic        dma_ack;
    logic [3:0]  byte_src_sel;
    logic        narrow_mode;
    logic [15:0] word_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;
    logic [15:0] exp_word;

    always #5 clk = ~clk;

    pio_input_latch dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_in        (line_in),
        .line_high_true (line_high_true),
        .flag_in        (flag_in),
        .flag_high_true (flag_high_true),
        .rd_strobe      (rd_strobe),
        .dma_mode       (dma_mode),
        .dma_ack        (dma_ack),
        .byte_src_sel   (byte_src_sel),
        .narrow_mode    (narrow_mode),
        .word_out       (word_out)
    );

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] logical(input logic [15:0] raw, input logic [15:0] ht);
        return raw ^ ~ht;
    endfunction

    // ev: 0 host read, 1 DMA read, 2 busy edge, 3 ready edge
    function automatic bit hits(input logic [1:0] sel, input int ev);
        case (sel)
            2'b01:   return ev == 2;
            2'b10:   return ev == 3;
            default: return ev == 0 || ev == 1;
        endcase
    endfunction

    task automatic pulse_strobe();
        rd_strobe = 1'b1; cycles(2); rd_strobe = 1'b0; cycles(6);
    endtask

    task automatic pulse_ack();
        dma_ack = 1'b1; cycles(2); dma_ack = 1'b0; cycles(6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n          = 1'b0;
        line_in        = 16'h0;
        line_high_true = 16'hFFFF;
        flag_high_true = 1'b0;
        flag_in        = 1'b1;   // low-true, raw high = ready
        rd_strobe      = 1'b0;
        dma_mode       = 1'b0;
        dma_ack        = 1'b0;
        byte_src_sel   = 4'b0000;
        narrow_mode    = 1'b0;
        cycles(5);
        rst_n = 1'b1;
        cycles(3);
        exp_word = 16'h0000;
        check16("R1 reset value", word_out, exp_word);

        // R9: exact latency, strobe and data change before the same edge
        line_in   = 16'hA5C3;
        rd_strobe = 1'b1;
        cycles(3);
        check16("R9 old value before fourth edge", word_out, exp_word);
        cycles(1);
        exp_word = 16'hA5C3;
        check16("R9 new value on fourth edge", word_out, exp_word);
        rd_strobe = 1'b0;
        cycles(4);

        // R2: lane mapping and per-line sense
        line_high_true = 16'h00FF;
        line_in        = 16'h1234;
        cycles(3);
        pulse_strobe();
        exp_word = 16'hED34;
        check16("R2 lanes and per-line polarity", word_out, exp_word);

        // Sweep every select pair against every event kind
        for (int s = 0; s < 16; s++) begin
            byte_src_sel   = 4'(s);
            flag_high_true = s[0] ^ s[2];
            flag_in        = ~flag_high_true;   // logical ready
            line_high_true = 16'(s * 16'h1F3B) ^ 16'hC0F0;
            cycles(4);
            for (int ev = 0; ev < 4; ev++) begin
                logic [15:0] raw;
                logic [15:0] nv;
                raw = 16'((s * 4 + ev + 1) * 16'h9E37) ^ 16'h5A3C;
                line_in = raw;
                if (ev == 1) dma_mode = 1'b1;
                cycles(4);
                check16("R11 hold while lines change", word_out, exp_word);
                if (ev == 0) begin
                    pulse_ack();
                    check16("R3 dma_ack ignored outside DMA mode", word_out, exp_word);
                    pulse_strobe();
                end else if (ev == 1) begin
                    pulse_strobe();
                    check16("R4 strobe ignored in DMA mode", word_out, exp_word);
                    pulse_ack();
                end else if (ev == 2) begin
                    flag_in = flag_high_true;    // logical busy
                    cycles(6);
                end else begin
                    flag_in = ~flag_high_true;   // logical ready
                    cycles(6);
                end
                nv = logical(raw, line_high_true);
                for (int b = 0; b < 2; b++) begin
                    logic [1:0] sel;
                    string tag;
                    sel = byte_src_sel[2*b +: 2];
                    if (hits(sel, ev)) begin
                        exp_word[8*b +: 8] = nv[8*b +: 8];
                        if (sel == 2'b11)  tag = "R7 reserved select";
                        else if (ev == 0)  tag = "R3 host read";
                        else if (ev == 1)  tag = "R4 DMA read";
                        else if (ev == 2)  tag = "R5 busy edge";
                        else               tag = "R6 ready edge";
                    end else begin
                        tag = "R8 lane not selected holds";
                    end
                    check8($sformatf("%s sel=%0d ev=%0d lane=%0d", tag, sel, ev, b),
                           word_out[8*b +: 8], exp_word[8*b +: 8]);
                end
                dma_mode = 1'b0;
            end
        end

        // R10: narrow mode freezes the high lane
        byte_src_sel   = 4'b0000;
        line_high_true = 16'hFFFF;
        narrow_mode    = 1'b1;
        for (int k = 0; k < 3; k++) begin
            line_in = 16'h3C00 + 16'(k * 16'h1111);
            cycles(3);
            pulse_strobe();
            exp_word[7:0] = line_in[7:0];
            check8("R10 high lane frozen in narrow mode", word_out[15:8], exp_word[15:8]);
            check8("R10 low lane loads in narrow mode", word_out[7:0], exp_word[7:0]);
        end
        narrow_mode = 1'b0;
        cycles(2);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule